// File: doc/BRIEF.md
# Timer count-clock source selector

This block chooses which event advances an 8-bit timer/event counter. Its output is a count-enable pulse that lasts one cycle. A 3-bit field in an 8-bit control register selects one of eight sources:

- either edge polarity of an asynchronous external event pin;
- one of six taps of a free-running prescaler that runs on the peripheral clock. The taps divide by 1, 2, 4, 64, 256 and 8192.

The enable reaches the counter only while the timer-run input is high. While the timer runs, the control register refuses writes, so the source cannot change in the middle of a count. A minimal 8-bit up-counter is included so that the enable can be observed at the ports.

A typical use is as follows:

1. Software stops the timer by pulling the run input low.
2. Software writes the source code.
3. Software raises the run input again.

The counter value is then read from the counter output.

Top module: `evt_clk_sel`

## Requirements
- R1: After reset the control register reads 0x00, which selects the falling edge of the event pin, and the counter reads 0x00.
- R2: With code 000 (bits 2:0), each falling edge of the event pin produces exactly one enable pulse. A rising edge produces none.
- R3: With code 001, each rising edge of the pin produces exactly one enable pulse. Suppose the pin changes after clock edge P0. The pulse is then high during the cycle that follows clock edge P2 and low in the cycles before and after it.
- R4: Codes 010, 011 and 100 give an enable on every cycle, every 2nd cycle and every 4th cycle. Over a run window of N cycles, where N is a multiple of the divisor D, exactly N/D pulses occur.
- R5: Codes 101, 110 and 111 give an enable every 64th, 256th and 8192nd cycle. Over a run window of N cycles, where N is a multiple of the divisor D, exactly N/D pulses occur.
- R6: Bits 7:3 of the control register are never stored and always read back as zero.
- R7: A write while the run input is high leaves the control register unchanged. This holds even when the write falls in a cycle that carries an enable pulse.
- R8: While the run input is low, the count-enable output is low and the counter holds its value.
- R9: The counter increases by exactly one at each clock edge where the enable is high, wraps from 0xFF to 0x00, and otherwise holds.
- R10: The enable is never high in two consecutive cycles, except with code 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset |
| wr_data | input | 8 | Control register write data |
| wr_en | input | 1 | Control register write strobe |
| rd_data | output | 8 | Control register read-back |
| run | input | 1 | Timer run; high blocks writes and passes the enable |
| evt_pin | input | 1 | Asynchronous external event pin |
| cnt_en | output | 1 | Single-cycle count-enable pulse |
| cnt_val | output | 8 | Demonstration counter value |

## Verification
A control-register write and a live count-enable pulse can fall in the same cycle, because the run input that blocks the write also lets the enable through. The bench runs the every-cycle source and raises the write strobe for a different code in the same cycle as the run input. It then checks two things: that the read-back still shows the old code, and that the pulse count for the window equals its length. A second coincidence is a pulse that arrives when the counter holds 0xFF. The bench steers the counter to that value and checks that the next enable leaves 0x00.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   localparam int unsigned CODE_FALL = 0;
   localparam int unsigned CODE_RISE = 1;
   localparam int unsigned FIRST_TAP = 2;

   // log2 of the division ratio for each prescaler code
   function automatic int unsigned tap_log2(input int unsigned code);
      case (code)
         2: return 0;
         3: return 1;
         4: return 2;
         5: return 6;
         6: return 8;
         7: return 13;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned max_tap_log2(input int unsigned num_src);
      int unsigned m;
      m = 0;
      for (int unsigned c = FIRST_TAP; c < num_src; c++)
         if (tap_log2(c) > m) m = tap_log2(c);
      return m;
   endfunction
endpackage

// File: rtl/tcs_edge_det.sv
module tcs_edge_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic rise_o,
   output logic fall_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tcs_edge_det: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
         prev_q <= pin_s;
      end
   end

   assign pin_s  = sync_q[SYNC_STAGES-1];
   assign rise_o = pin_s & ~prev_q;
   assign fall_o = ~pin_s & prev_q;
endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
   import tcs_pkg::*;
#(
   parameter int unsigned PRE_W    = 13,
   parameter int unsigned NUM_TAPS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_TAPS-1:0] tap_en
);
   localparam int unsigned NEED_W = max_tap_log2(NUM_TAPS + FIRST_TAP);

   if (PRE_W < NEED_W) begin : g_bad_width
      $error("tcs_prescaler: PRE_W too narrow for the widest tap");
   end

   logic [PRE_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + {{(PRE_W-1){1'b0}}, 1'b1};
   end

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int unsigned K = tap_log2(i + FIRST_TAP);
      if (K == 0) begin : g_every
         assign tap_en[i] = 1'b1;
      end else begin : g_div
         assign tap_en[i] = &div_q[K-1:0];
      end
   end
endmodule

// File: rtl/tcs_demo_cnt.sv
module tcs_demo_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [CNT_W-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= '0;
      else if (step) value <= value + {{(CNT_W-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/evt_clk_sel.sv
module evt_clk_sel
   import tcs_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned PRE_W       = 13,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              run,
   input  logic              evt_pin,
   output logic              cnt_en,
   output logic [CNT_W-1:0]  cnt_val
);
   localparam int unsigned NUM_SRC  = 2 ** SEL_W;
   localparam int unsigned NUM_TAPS = NUM_SRC - FIRST_TAP;

   if (SEL_W != 3) begin : g_bad_sel
      $error("evt_clk_sel: the source map is defined for SEL_W = 3");
   end
   if (DATA_W <= SEL_W) begin : g_bad_data
      $error("evt_clk_sel: DATA_W must exceed SEL_W");
   end

   logic [SEL_W-1:0]    sel_q;
   logic [NUM_SRC-1:0]  src_vec;
   logic [NUM_TAPS-1:0] tap_en;
   logic                pin_rise;
   logic                pin_fall;
   logic                unused_wr_hi;

   // selection register: updates only while stopped, high bits dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               sel_q <= '0;
      else if (wr_en && !run)   sel_q <= wr_data[SEL_W-1:0];
   end

   assign unused_wr_hi = ^wr_data[DATA_W-1:SEL_W];
   assign rd_data      = {{(DATA_W-SEL_W){1'b0}}, sel_q};

   tcs_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (evt_pin),
      .rise_o    (pin_rise),
      .fall_o    (pin_fall)
   );

   tcs_prescaler #(.PRE_W(PRE_W), .NUM_TAPS(NUM_TAPS)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tap_en (tap_en)
   );

   assign src_vec[CODE_FALL] = pin_fall;
   assign src_vec[CODE_RISE] = pin_rise;
   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_map
      assign src_vec[i + FIRST_TAP] = tap_en[i];
   end

   assign cnt_en = run & src_vec[sel_q];

   tcs_demo_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (cnt_en),
      .value (cnt_val)
   );
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              run,
   input logic              cnt_en,
   input logic [CNT_W-1:0]  cnt_val
);
   // R6
   a_r6_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[DATA_W-1:3] == '0);

   // R7
   a_r7_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wr_en) |=> $stable(rd_data));

   // R8
   a_r8_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !cnt_en);

   // R9
   a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> (cnt_val == $past(cnt_val) + 1'b1));

   // R9
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt_val));

   // R10
   a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && rd_data[2:0] != 3'b010) |=> !cnt_en);
endmodule

bind evt_clk_sel tcs_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_data (rd_data),
   .run     (run),
   .cnt_en  (cnt_en),
   .cnt_val (cnt_val)
);

// File: tb/evt_clk_sel_bench.sv
module evt_clk_sel_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [2:0]  code;
      logic [31:0] len;   // cycles for taps, edges for pin codes
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{3'd2, 32'd300,   32'd300},
      '{3'd3, 32'd300,   32'd150},
      '{3'd4, 32'd300,   32'd75},
      '{3'd5, 32'd640,   32'd10},
      '{3'd6, 32'd1024,  32'd4},
      '{3'd7, 32'd16384, 32'd2},
      '{3'd0, 32'd5,     32'd5},
      '{3'd1, 32'd6,     32'd6}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_en = 1'b0;
   logic [7:0] rd_data;
   logic       run = 1'b0;
   logic       evt_pin = 1'b0;
   logic       cnt_en;
   logic [7:0] cnt_val;

   int n_chk = 0;
   int n_fail = 0;
   int pulses = 0;

   evt_clk_sel u_evt_clk_sel (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en),
      .rd_data(rd_data), .run(run), .evt_pin(evt_pin),
      .cnt_en(cnt_en), .cnt_val(cnt_val)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (cnt_en) pulses++;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic run_for(input int k);
      @(posedge clk); #1; run = 1'b1;
      repeat (k) @(posedge clk);
      #1; run = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int p0;
      int c0;
      int seen;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ctrl reset", rd_data, 0);
      check("R1 counter reset", cnt_val, 0);
      check("R8 enable low when stopped", cnt_en, 0);

      // vector table: R2 R3 R4 R5 R9
      for (int v = 0; v < NV; v++) begin
         wr({5'b0, VEC[v].code});
         p0 = pulses; c0 = cnt_val;
         if (VEC[v].code < 3'd2) begin
            @(posedge clk); #1; run = 1'b1;
            for (int j = 0; j < int'(VEC[v].len); j++) begin
               evt_pin = 1'b1; repeat (5) @(posedge clk); #1;
               evt_pin = 1'b0; repeat (5) @(posedge clk); #1;
            end
            run = 1'b0;
         end else begin
            run_for(int'(VEC[v].len));
         end
         @(negedge clk);
         check($sformatf("R4 R5 R2 R3 pulses code %0d", VEC[v].code),
               pulses - p0, int'(VEC[v].exp));
         check($sformatf("R9 counter delta code %0d", VEC[v].code),
               (cnt_val - c0) & 8'hFF, int'(VEC[v].exp) % 256);
      end

      // R6 high bits dropped
      wr(8'hFD);
      @(negedge clk);
      check("R6 readback", rd_data, 8'h05);

      // R8 stopped: no pulses with every-cycle source
      wr(8'h02);
      p0 = pulses; c0 = cnt_val;
      repeat (40) @(posedge clk);
      @(negedge clk);
      check("R8 no pulses stopped", pulses - p0, 0);
      check("R8 counter holds", cnt_val, c0);

      // R7 write in the same cycle as running and a pulse
      p0 = pulses;
      @(posedge clk); #1; run = 1'b1; wr_en = 1'b1; wr_data = 8'h07;
      @(posedge clk); #1; wr_en = 1'b0;
      repeat (9) @(posedge clk);
      #1; run = 1'b0;
      @(negedge clk);
      check("R7 write ignored while running", rd_data, 2);
      check("R7 counting unaffected", pulses - p0, 10);

      // R9 wrap from 0xFF
      run_for((8'hFF - cnt_val) & 8'hFF);
      @(negedge clk);
      check("R9 reach FF", cnt_val, 8'hFF);
      run_for(1);
      @(negedge clk);
      check("R9 wrap to 00", cnt_val, 0);

      // R3 latency and width
      wr(8'h01);
      @(posedge clk); #1; run = 1'b1;
      @(posedge clk); #1; evt_pin = 1'b1;
      seen = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         seen = (seen << 1) | int'(cnt_en);
      end
      check("R3 pulse timing 0010", seen, 2);
      evt_pin = 1'b0;
      repeat (5) @(posedge clk); #1; run = 1'b0;

      // R2 falling only
      wr(8'h00);
      @(posedge clk); #1; run = 1'b1;
      p0 = pulses;
      evt_pin = 1'b1; repeat (6) @(posedge clk);
      @(negedge clk);
      check("R2 rising ignored", pulses - p0, 0);
      #1 evt_pin = 1'b0; repeat (6) @(posedge clk);
      @(negedge clk);
      check("R2 falling counted", pulses - p0, 1);
      run = 1'b0;

      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule